// File: doc/BRIEF.md
# UART DMA Request Controller

This block sits beside the receive and transmit FIFOs of a UART and decides when a DMA engine should be asked to move characters. Each direction drives two request lines. A single request asks for one character. A burst request asks for a block of characters sized by a programmable trigger level. Each direction has its own enable. An optional error stop holds receive requests off after a line error until software clears that error.

The block also keeps three sticky status flags. The first records that the receive DMA transfer has finished. The second records that the transmit DMA transfer has finished. The third records the end of transmission, which is when the serializer goes idle after shifting out its last bit. Each flag has a mask bit, and the unmasked flags are ORed into one interrupt line. Flags are cleared with write-1 strobes.

There is no data path through the block, so every pin is a plain level or a one-cycle pulse. No valid/ready handshake is needed, and the block applies no back-pressure. The FIFO occupancy inputs are `$clog2(FIFO_DEPTH+1)` bits wide, so a full 16-entry FIFO reads as 16.

Top module: `uart_dma_req_ctrl`

## Requirements
- R1: `rx_sreq` is high in the same cycle whenever `rx_dma_en` is 1, receive requests are not error-blocked, and `rx_level` is at least 1.
- R2: `rx_breq` is high in the same cycle whenever `rx_dma_en` is 1, receive requests are not blocked, and `rx_level >= rx_thresh`.
- R3: `tx_sreq` is high in the same cycle whenever `tx_dma_en` is 1 and `tx_level < FIFO_DEPTH`.
- R4: `tx_breq` is high in the same cycle whenever `tx_dma_en` is 1 and `tx_level < tx_thresh`.
- R5: While a channel's enable is 0, both of that channel's request lines are 0, whatever the levels.
- R6: A cycle with `rx_err` and `err_stop_en` both at 1 blocks both receive requests from the next cycle on. The block lasts until the cycle after an `err_clr` pulse. If `rx_err` and `err_clr` fall in the same cycle, the block is set. With `err_stop_en` at 0, `rx_err` has no effect. Transmit requests are never blocked.
- R7: A `rx_done` pulse sets `sts[0]` and a `tx_done` pulse sets `sts[1]` on the next clock edge. The bits stay set until they are cleared.
- R8: While `eot_en` is 1, a rising edge of `ser_idle` (1 now, 0 in the previous cycle) sets `sts[2]` on that clock edge. While `eot_en` is 0, it does not.
- R9: `sts_clr[i]` at 1 clears `sts[i]` at the next edge. A set event for the same bit in the same cycle wins, and the bit stays 1.
- R10: `irq` is 1 exactly when some bit of `sts & int_mask` is 1. It reflects the current status with no extra delay.
- R11: After reset, `sts` is 0, `irq` is 0 and no receive block is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | CNT_W | Receive FIFO occupancy (0..FIFO_DEPTH) |
| tx_level | input | CNT_W | Transmit FIFO occupancy (0..FIFO_DEPTH) |
| rx_thresh | input | CNT_W | Receive burst trigger level |
| tx_thresh | input | CNT_W | Transmit burst trigger level |
| rx_dma_en | input | 1 | Receive channel enable |
| tx_dma_en | input | 1 | Transmit channel enable |
| err_stop_en | input | 1 | Block receive DMA after a receive error |
| rx_err | input | 1 | Receive error event pulse |
| err_clr | input | 1 | Error interrupt clear pulse |
| rx_done | input | 1 | Receive DMA completion pulse |
| tx_done | input | 1 | Transmit DMA completion pulse |
| eot_en | input | 1 | End-of-transmission detection enable |
| ser_idle | input | 1 | Serializer idle level |
| sts_clr | input | 3 | Write-1 clear strobes for sts |
| int_mask | input | 3 | Interrupt mask per status bit |
| rx_sreq | output | 1 | Receive single request |
| rx_breq | output | 1 | Receive burst request |
| tx_sreq | output | 1 | Transmit single request |
| tx_breq | output | 1 | Transmit burst request |
| sts | output | 3 | Status: [0] rx done, [1] tx done, [2] end of transmission |
| irq | output | 1 | Masked OR of status |

## Verification
A status set event and its write-1 clear strobe can land in the same cycle. So can a receive error and the error clear. The bench drives `rx_done` together with `sts_clr[0]`, and `rx_err` together with `err_clr`, in one cycle. It then checks after the next edge that the status bit is still 1 and that the receive requests stay low. A clear strobe alone is then applied, to show that the bit and the block do drop when no set event competes.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;
  localparam int STS_W      = 3;
  localparam int STS_RXDONE = 0;
  localparam int STS_TXDONE = 1;
  localparam int STS_EOT    = 2;
endpackage

// File: rtl/udr_req_gen.sv
module udr_req_gen #(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5,
  parameter bit IS_TX  = 1'b0
) (
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] thresh,
  input  logic             en,
  input  logic             hold,
  output logic             sreq,
  output logic             breq
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic s_raw, b_raw, pass;

  assign pass = en & ~hold;

  generate
    if (IS_TX) begin : g_tx
      // room for one more, or below the refill level
      assign s_raw = (level < FULL);
      assign b_raw = (level < thresh);
    end else begin : g_rx
      // something to read, or at/above the drain level
      assign s_raw = (level != '0);
      assign b_raw = (level >= thresh);
    end
  endgenerate

  assign sreq = pass & s_raw;
  assign breq = pass & b_raw;
endmodule

// File: rtl/udr_err_hold.sv
module udr_err_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_en,
  input  logic err,
  input  logic clr,
  output logic hold
);
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_q <= 1'b0;
    else if (stop_en && err) hold_q <= 1'b1;
    else if (clr)            hold_q <= 1'b0;
  end

  assign hold = hold_q;
endmodule

// File: rtl/udr_sts_bank.sv
module udr_sts_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] sts
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= set[i] | (q & ~clr[i]);
      end
      assign sts[i] = q;
    end
  endgenerate
endmodule

// File: rtl/uart_dma_req_ctrl.sv
module uart_dma_req_ctrl
  import uart_dma_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] tx_level,
  input  logic [CNT_W-1:0] rx_thresh,
  input  logic [CNT_W-1:0] tx_thresh,
  input  logic             rx_dma_en,
  input  logic             tx_dma_en,
  input  logic             err_stop_en,
  input  logic             rx_err,
  input  logic             err_clr,
  input  logic             rx_done,
  input  logic             tx_done,
  input  logic             eot_en,
  input  logic             ser_idle,
  input  logic [STS_W-1:0] sts_clr,
  input  logic [STS_W-1:0] int_mask,
  output logic             rx_sreq,
  output logic             rx_breq,
  output logic             tx_sreq,
  output logic             tx_breq,
  output logic [STS_W-1:0] sts,
  output logic             irq
);
  logic             rx_hold;
  logic             idle_q;
  logic             eot_hit;
  logic [STS_W-1:0] sts_set;

  udr_err_hold u_hold (
    .clk(clk), .rst_n(rst_n), .stop_en(err_stop_en),
    .err(rx_err), .clr(err_clr), .hold(rx_hold)
  );

  udr_req_gen #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .IS_TX(1'b0)) u_rx (
    .level(rx_level), .thresh(rx_thresh), .en(rx_dma_en),
    .hold(rx_hold), .sreq(rx_sreq), .breq(rx_breq)
  );

  udr_req_gen #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .IS_TX(1'b1)) u_tx (
    .level(tx_level), .thresh(tx_thresh), .en(tx_dma_en),
    .hold(1'b0), .sreq(tx_sreq), .breq(tx_breq)
  );

  // idle history starts high so reset release is not seen as an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= 1'b1;
    else        idle_q <= ser_idle;
  end

  assign eot_hit = eot_en & ser_idle & ~idle_q;

  always_comb begin
    sts_set             = '0;
    sts_set[STS_RXDONE] = rx_done;
    sts_set[STS_TXDONE] = tx_done;
    sts_set[STS_EOT]    = eot_hit;
  end

  udr_sts_bank #(.N(STS_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .set(sts_set), .clr(sts_clr), .sts(sts)
  );

  assign irq = |(sts & int_mask);
endmodule

// File: rtl/udr_chk.sv
module udr_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] rx_level,
  input logic [CNT_W-1:0] tx_level,
  input logic [CNT_W-1:0] tx_thresh,
  input logic             tx_dma_en,
  input logic             rx_dma_en,
  input logic             err_stop_en,
  input logic             rx_err,
  input logic             rx_done,
  input logic             tx_done,
  input logic [2:0]       sts_clr,
  input logic [2:0]       sts,
  input logic             rx_sreq,
  input logic             rx_breq,
  input logic             tx_sreq,
  input logic             tx_breq
);
  // R1
  rx_single_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sreq |-> (rx_dma_en && rx_level != '0));

  // R4
  tx_burst_implies_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_breq && tx_thresh <= CNT_W'(DEPTH)) |-> tx_sreq);

  // R5
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_dma_en |-> (!tx_sreq && !tx_breq));

  // R6
  err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && err_stop_en) |=> (!rx_sreq && !rx_breq));

  // R7
  rx_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> sts[0]);

  // R7
  tx_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> sts[1]);

  // R9
  rx_done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr[0] && !rx_done) |=> !sts[0]);

  // R3
  tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == CNT_W'(DEPTH)) |-> !tx_sreq);
endmodule

bind uart_dma_req_ctrl udr_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
  .tx_thresh(tx_thresh), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
  .err_stop_en(err_stop_en), .rx_err(rx_err), .rx_done(rx_done),
  .tx_done(tx_done), .sts_clr(sts_clr), .sts(sts), .rx_sreq(rx_sreq),
  .rx_breq(rx_breq), .tx_sreq(tx_sreq), .tx_breq(tx_breq)
);

// File: tb/uart_dma_req_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_dma_req_ctrl_tb_top;
  localparam int DEPTH = 16;
  localparam int CW    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] rx_level = '0, tx_level = '0, rx_thresh = '0, tx_thresh = '0;
  logic rx_dma_en = 0, tx_dma_en = 0, err_stop_en = 0, rx_err = 0, err_clr = 0;
  logic rx_done = 0, tx_done = 0, eot_en = 0, ser_idle = 1;
  logic [2:0] sts_clr = '0, int_mask = '0;
  logic rx_sreq, rx_breq, tx_sreq, tx_breq, irq;
  logic [2:0] sts;

  int checks = 0;
  int fails  = 0;
  bit done_run = 0;

  always #2 clk = ~clk;

  uart_dma_req_ctrl #(.FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
    .rx_thresh(rx_thresh), .tx_thresh(tx_thresh), .rx_dma_en(rx_dma_en),
    .tx_dma_en(tx_dma_en), .err_stop_en(err_stop_en), .rx_err(rx_err),
    .err_clr(err_clr), .rx_done(rx_done), .tx_done(tx_done), .eot_en(eot_en),
    .ser_idle(ser_idle), .sts_clr(sts_clr), .int_mask(int_mask),
    .rx_sreq(rx_sreq), .rx_breq(rx_breq), .tx_sreq(tx_sreq), .tx_breq(tx_breq),
    .sts(sts), .irq(irq)
  );

  task automatic chk(input logic [3:0] got, input logic [3:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", req, got, exp, $time);
    end
  endtask

  // advance one edge, then move 1 ns past it
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done_run) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R11 reset state
    chk({1'b0, sts}, 4'h0, "R11 sts");
    chk({3'b0, irq}, 4'h0, "R11 irq");
    rst_n = 1'b1;
    step();
    chk({3'b0, irq}, 4'h0, "R11 irq after release");

    // R1 R2 sweep of receive level and threshold
    rx_dma_en = 1;
    for (int c = 0; c <= DEPTH; c++) begin
      for (int t = 0; t <= DEPTH; t++) begin
        rx_level = CW'(c); rx_thresh = CW'(t); #1;
        chk({3'b0, rx_sreq}, {3'b0, c >= 1}, "R1 rx single");
        chk({3'b0, rx_breq}, {3'b0, c >= t}, "R2 rx burst");
      end
    end

    // R3 R4 sweep of transmit level and threshold
    tx_dma_en = 1;
    for (int c = 0; c <= DEPTH; c++) begin
      for (int t = 0; t <= DEPTH; t++) begin
        tx_level = CW'(c); tx_thresh = CW'(t); #1;
        chk({3'b0, tx_sreq}, {3'b0, c < DEPTH}, "R3 tx single");
        chk({3'b0, tx_breq}, {3'b0, c < t}, "R4 tx burst");
      end
    end

    // R5 enables off
    rx_dma_en = 0; tx_dma_en = 0;
    for (int c = 0; c <= DEPTH; c++) begin
      rx_level = CW'(c); tx_level = CW'(c); rx_thresh = 1; tx_thresh = 16; #1;
      chk({2'b0, rx_sreq, rx_breq}, 4'h0, "R5 rx gated");
      chk({2'b0, tx_sreq, tx_breq}, 4'h0, "R5 tx gated");
    end

    // R6 error stop
    rx_dma_en = 1; tx_dma_en = 1; rx_level = 5; rx_thresh = 2;
    tx_level = 3; tx_thresh = 8; err_stop_en = 1;
    step();
    rx_err = 1; step(); rx_err = 0;
    chk({2'b0, rx_sreq, rx_breq}, 4'h0, "R6 blocked after error");
    chk({2'b0, tx_sreq, tx_breq}, 4'h3, "R6 tx unaffected");
    step(); step();
    chk({2'b0, rx_sreq, rx_breq}, 4'h0, "R6 block persists");
    err_clr = 1; step(); err_clr = 0;
    chk({2'b0, rx_sreq, rx_breq}, 4'h3, "R6 released by clear");
    rx_err = 1; err_clr = 1; step(); rx_err = 0; err_clr = 0;
    chk({2'b0, rx_sreq, rx_breq}, 4'h0, "R6 error beats clear");
    err_clr = 1; step(); err_clr = 0;
    err_stop_en = 0; rx_err = 1; step(); rx_err = 0;
    chk({2'b0, rx_sreq, rx_breq}, 4'h3, "R6 no stop when disabled");

    // R7 R10 completion status and masking
    int_mask = 3'b000;
    rx_done = 1; step(); rx_done = 0;
    chk({1'b0, sts}, 4'h1, "R7 rx done set");
    chk({3'b0, irq}, 4'h0, "R10 masked");
    tx_done = 1; step(); tx_done = 0;
    chk({1'b0, sts}, 4'h3, "R7 tx done set, sticky");
    int_mask = 3'b010; #1;
    chk({3'b0, irq}, 4'h1, "R10 tx bit unmasked");
    int_mask = 3'b100; #1;
    chk({3'b0, irq}, 4'h0, "R10 only eot unmasked");

    // R9 concurrent set and clear, then clear alone
    sts_clr = 3'b001; rx_done = 1; step(); sts_clr = 0; rx_done = 0;
    chk({1'b0, sts}, 4'h3, "R9 set wins over clear");
    sts_clr = 3'b011; step(); sts_clr = 0;
    chk({1'b0, sts}, 4'h0, "R9 cleared");

    // R8 end of transmission
    eot_en = 0; ser_idle = 0; step(); ser_idle = 1; step();
    chk({1'b0, sts}, 4'h0, "R8 ignored when disabled");
    eot_en = 1; step(); step();
    chk({1'b0, sts}, 4'h0, "R8 steady idle no edge");
    ser_idle = 0; step(); step();
    chk({1'b0, sts}, 4'h0, "R8 busy no set");
    ser_idle = 1; step();
    chk({1'b0, sts}, 4'h4, "R8 idle rise sets");
    chk({3'b0, irq}, 4'h1, "R10 eot irq");
    sts_clr = 3'b100; step(); sts_clr = 0;
    chk({1'b0, sts}, 4'h0, "R9 eot cleared");

    done_run = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule